// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a clock-enable that pulses at a nominal 32768 Hz into a one-cycle seconds tick. A 16-bit calibration word applies a signed trim to the long-term rate, so a crystal that runs slightly fast or slow can still keep accurate seconds. The trim works over a correction window of input ticks. In each window the prescaler counts a programmed number of extra ticks as elapsed when the trim is positive, or withholds that many ticks when it is negative.

There are two window sizes. The fine window is 2^20 ticks, which gives about 954 ppb per step. The coarse window is 2^18 ticks, which gives about 3815 ppb per step. The calibration word is sampled only on the first input tick of each window. A word whose guard bits are inconsistent with its sign is replaced by the nominal setting, and a sticky error flag is raised. The parent logic holds the word and counts the seconds.

Top module: `trim_prescaler`

## Requirements
- R1: While reset is asserted and just after it is released, `sec_tick` and `cal_err` are both 0.
- R2: With the nominal word 16'h2000, one `sec_tick` pulse comes for every `TICKS_PER_SEC` pulses of `slow_en`. The pulse appears in the cycle after the enable pulse that completes the count.
- R3: Bit 15 = 0 selects fine mode, with a window of 2^`FINE_LOG2` ticks. Bits [7:0] form a two's-complement trim. A positive trim adds that many counts of advance per window, so k windows give floor(k·(2^FINE_LOG2 + trim)/TICKS_PER_SEC) ticks.
- R4: A negative trim in bits [7:0] withholds |trim| counts of advance per window.
- R5: Bit 15 = 1 selects coarse mode, with a window of 2^`COARSE_LOG2` ticks and the same per-window trim rule.
- R6: The extreme trims, +127 and -128, are applied in full in both modes.
- R7: The guard field, bits [14:8], must equal {0, ~S, S, S, S, S, S}, where S is bit 7. When it does not, the window runs untrimmed in fine mode and `cal_err` is set.
- R8: Once set, `cal_err` stays at 1 until reset, even after a valid word is supplied.
- R9: A change of the calibration word during a window is ignored until the first tick of the next window.
- R10: `sec_tick` is never high for two cycles in a row. It only rises in the cycle after an enable pulse. With `slow_en` low, the count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle enable at the nominal 32768 Hz rate |
| cal_word | input | 16 | Calibration word: mode, guard field, signed trim |
| sec_tick | output | 1 | One-cycle seconds pulse |
| cal_err | output | 1 | Sticky flag for a calibration word whose guard field mismatches |

## Verification
Two events can fall on the same input tick. The tick that opens a window also samples a new calibration word, and it may be the tick that completes a second or the tick on which the last trim count of the previous window is spent. The bench provokes this by running whole windows with trims of up to ±128, and by changing the word halfway through a window. It judges the outcome by the total number of seconds pulses at the window boundary. Any count applied early or late, and any adoption of the new word mid-window, changes that total.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // Decoded calibration settings, captured at each window start.
  typedef struct packed {
    logic       coarse;   // 1: short (coarse) window
    logic       neg;      // trim withholds ticks
    logic [7:0] mag;      // |trim|, 0..128
    logic       bad;      // guard field inconsistent with sign
  } trim_cfg_t;
endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import trim_pkg::*;
(
  input  logic [15:0] cal_word,
  output trim_cfg_t   cfg
);
  logic       sgn;
  logic [6:0] want_guard;
  logic       guard_ok;

  always_comb begin
    sgn        = cal_word[7];
    want_guard = {1'b0, ~sgn, {5{sgn}}};
    guard_ok   = (cal_word[14:8] == want_guard);
    if (guard_ok) begin
      cfg.coarse = cal_word[15];
      cfg.neg    = sgn;
      cfg.mag    = sgn ? (~cal_word[7:0] + 8'd1) : cal_word[7:0];
      cfg.bad    = 1'b0;
    end else begin
      cfg.coarse = 1'b0;
      cfg.neg    = 1'b0;
      cfg.mag    = 8'd0;
      cfg.bad    = 1'b1;
    end
  end
endmodule

// File: rtl/trim_window_seq.sv
module trim_window_seq
  import trim_pkg::*;
#(
  parameter int FINE_LOG2   = 20,
  parameter int COARSE_LOG2 = 18
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slow_en,
  input  trim_cfg_t cfg_in,
  output logic      corr_add,
  output logic      corr_sub,
  output logic      err_flag
);
  localparam int WIN_W = FINE_LOG2;
  localparam logic [WIN_W-1:0] FINE_LAST   = {WIN_W{1'b1}};
  localparam logic [WIN_W-1:0] COARSE_LAST = WIN_W'((64'd1 << COARSE_LOG2) - 64'd1);

  logic [WIN_W-1:0] win_q, win_d;
  logic             coarse_q, coarse_d;
  logic             neg_q, neg_d;
  logic [7:0]       left_q, left_d;
  logic             err_q, err_d;
  logic             win_start;
  logic             win_last;
  logic             corr_on;

  always_comb begin
    win_start = (win_q == '0);
    win_last  = coarse_q ? (win_q == COARSE_LAST) : (win_q == FINE_LAST);
    corr_on   = slow_en && !win_start && (left_q != 8'd0);

    win_d    = win_q;
    coarse_d = coarse_q;
    neg_d    = neg_q;
    left_d   = left_q;
    err_d    = err_q;

    if (slow_en) begin
      if (win_start) begin
        coarse_d = cfg_in.coarse;
        neg_d    = cfg_in.neg;
        left_d   = cfg_in.mag;
        err_d    = err_q | cfg_in.bad;
        win_d    = WIN_W'(1);
      end else begin
        win_d = win_last ? '0 : win_q + WIN_W'(1);
        if (corr_on) begin
          left_d = left_q - 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      coarse_q <= 1'b0;
      neg_q    <= 1'b0;
      left_q   <= 8'd0;
      err_q    <= 1'b0;
    end else begin
      win_q    <= win_d;
      coarse_q <= coarse_d;
      neg_q    <= neg_d;
      left_q   <= left_d;
      err_q    <= err_d;
    end
  end

  assign corr_add = corr_on && !neg_q;
  assign corr_sub = corr_on && neg_q;
  assign err_flag = err_q;
endmodule

// File: rtl/trim_tick_div.sv
module trim_tick_div #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_en,
  input  logic corr_add,
  input  logic corr_sub,
  output logic tick
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS_PER_SEC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] sum;
  logic             tick_d, tick_q;

  always_comb begin
    if (!slow_en)      step = '0;
    else if (corr_add) step = CNT_W'(2);
    else if (corr_sub) step = '0;
    else               step = CNT_W'(1);
    sum    = cnt_q + step;
    tick_d = (sum >= LIMIT);
    cnt_d  = tick_d ? (sum - LIMIT) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FINE_LOG2     = 20,
  parameter int COARSE_LOG2   = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic [15:0] cal_word,
  output logic        sec_tick,
  output logic        cal_err
);
  trim_cfg_t cfg;
  logic      corr_add;
  logic      corr_sub;

  trim_decode u_dec (
    .cal_word (cal_word),
    .cfg      (cfg)
  );

  trim_window_seq #(
    .FINE_LOG2   (FINE_LOG2),
    .COARSE_LOG2 (COARSE_LOG2)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_en  (slow_en),
    .cfg_in   (cfg),
    .corr_add (corr_add),
    .corr_sub (corr_sub),
    .err_flag (cal_err)
  );

  trim_tick_div #(
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_en  (slow_en),
    .corr_add (corr_add),
    .corr_sub (corr_sub),
    .tick     (sec_tick)
  );
endmodule

// File: rtl/trim_prescaler_chk.sv
module trim_prescaler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_en,
  input logic [15:0] cal_word,
  input logic        sec_tick,
  input logic        cal_err
);
  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_tick_after_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_tick) |-> $past(slow_en));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |=> cal_err);

  assert_err_on_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_err) |-> $past(slow_en));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_en |=> !sec_tick);
endmodule

bind trim_prescaler trim_prescaler_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_en  (slow_en),
  .cal_word (cal_word),
  .sec_tick (sec_tick),
  .cal_err  (cal_err)
);

// File: tb/tb_trim_prescaler.sv
`timescale 1ns/1ps
module tb_trim_prescaler;
  localparam int T  = 64;
  localparam int FL = 10;
  localparam int CL = 8;

  logic        clk;
  logic        rst_n;
  logic        slow_en;
  logic [15:0] cal_word;
  logic        sec_tick;
  logic        cal_err;

  int checks = 0;
  int fails  = 0;
  int ticks  = 0;

  trim_prescaler #(.TICKS_PER_SEC(T), .FINE_LOG2(FL), .COARSE_LOG2(CL)) dut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .cal_word(cal_word),
    .sec_tick(sec_tick), .cal_err(cal_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {cal_word, gap between enables}
  localparam logic [19:0] VEC [0:7] = '{
    {16'h2000, 4'd1},   // R2 nominal
    {16'h2064, 4'd1},   // R3 +100 fine
    {16'h1F9C, 4'd1},   // R4 -100 fine
    {16'hA07F, 4'd1},   // R5 R6 coarse +127
    {16'h9F80, 4'd2},   // R5 R6 coarse -128
    {16'h207F, 4'd3},   // R6 fine +127
    {16'h0064, 4'd1},   // R7 guard mismatch
    {16'h3F9C, 4'd2}    // R7 guard mismatch, negative
  };

  function automatic bit ref_bad(input logic [15:0] w);
    logic s;
    s = w[7];
    return !(w[14] == 1'b0 && w[13] == !s && w[12:8] == {5{s}});
  endfunction

  function automatic int ref_len(input logic [15:0] w);
    if (ref_bad(w)) return (1 << FL);
    return w[15] ? (1 << CL) : (1 << FL);
  endfunction

  function automatic int ref_off(input logic [15:0] w);
    if (ref_bad(w)) return 0;
    return int'($signed(w[7:0]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en);
    @(negedge clk);
    slow_en = en;
    @(posedge clk);
    #1;
    if (sec_tick) ticks++;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      for (int g = 1; g < gap; g++) cyc(1'b0);
    end
    cyc(1'b0);
    cyc(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    slow_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ticks = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    slow_en  = 1'b0;
    cal_word = 16'h2000;
    #1;
    check("R1 tick in reset", int'(sec_tick), 0);
    check("R1 err in reset", int'(cal_err), 0);
    do_reset();
    @(posedge clk); #1;
    check("R1 tick after reset", int'(sec_tick), 0);
    check("R1 err after reset", int'(cal_err), 0);

    // Vector walk: two whole windows per vector.
    for (int v = 0; v < 8; v++) begin
      logic [15:0] w;
      int gap, len, exp_t;
      w   = VEC[v][19:4];
      gap = int'(VEC[v][3:0]);
      len = ref_len(w);
      exp_t = (2 * (len + ref_off(w))) / T;
      do_reset();
      cal_word = w;
      run(2 * len, gap);
      check($sformatf("R3-R7 ticks vec%0d", v), ticks, exp_t);
      check($sformatf("R7 err vec%0d", v), int'(cal_err), int'(ref_bad(w)));
    end

    // R2 exact pulse timing and R10 single cycle / freeze.
    do_reset();
    cal_word = 16'h2000;
    for (int i = 0; i < T - 1; i++) cyc(1'b1);
    check("R2 no tick before count", ticks, 0);
    cyc(1'b1);
    check("R2 tick after last enable", int'(sec_tick), 1);
    cyc(1'b0);
    check("R10 tick one cycle", int'(sec_tick), 0);
    ticks = 0;
    for (int i = 0; i < 3 * T; i++) cyc(1'b0);
    check("R10 frozen without enable", ticks, 0);

    // R9 mid-window change takes effect at next window.
    do_reset();
    cal_word = 16'h2000;
    run((1 << FL) / 2, 1);
    cal_word = 16'h2064;
    run((1 << FL) / 2 + (1 << FL), 1);
    check("R9 deferred calibration", ticks, ((1 << FL) + (1 << FL) + 100) / T);

    // R8 sticky error after a valid word.
    do_reset();
    cal_word = 16'h0064;
    run(1 << FL, 1);
    check("R8 err set", int'(cal_err), 1);
    cal_word = 16'h2000;
    run(2 * (1 << FL), 1);
    check("R8 err remains", int'(cal_err), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule